// File: doc/BRIEF.md
# Flash-Card Cold-Boot Sequencer

This block lets a processor start without any boot ROM. At power-up, or when the reset button is pressed, it holds the processor in reset and drives the flash card's 16-bit register interface on its own. It waits for the card to report ready, then issues a one-sector read of logical sector 1 and waits for the card to report data available. Only then does it release the processor.

From that point, processor memory reads in the low 512-byte window go to the card's data register instead of RAM. That register is a stream, so each read returns the next 16-bit word of the boot sector, whatever address is presented. The boot code is therefore written as straight-line code with no loops. It copies a loader into RAM and jumps to it. It then clears a control bit, and the window goes back to ordinary memory.

After release, processor I/O cycles to the card's eight-register range reach the card through the same strobe engine. All other memory cycles are passed to normal memory through a select output.

Top module: `cf_boot_seq`

## Requirements
- R1: After power-on reset or a button press, `cpu_rst_n` is 0 and the remap bit is 1, and `cpu_rst_n` stays 0 until the boot sequence has finished.
- R2: The first card activity is a series of status reads (register select 7). These repeat until a read returns bit 7 (busy) = 0 and bit 6 (ready) = 1. No card write happens before such a read.
- R3: Exactly six card writes follow, in this order, given as (select, value): (2, 0x01), (3, 0x01), (4, 0x00), (5, 0x00), (6, 0x00), (7, 0x20).
- R4: After the command write, status is read repeatedly until bit 7 = 0 and bit 3 (data request) = 1. Only after that read does `cpu_rst_n` rise, and the remap bit is 1 at that moment.
- R5: While the remap bit is 1, each processor memory read in 0x000–0x1FF becomes a card read of the data register (select 0). Successive reads return successive sector words, regardless of the address presented.
- R6: Memory reads at or above 0x200, memory writes, and memory reads while the remap bit is 0 assert `mem_sel` and cause no card strobe. `mem_sel` is never asserted while `cpu_rst_n` is 0.
- R7: After release, an I/O cycle whose address has bits [7:3] equal to 0xC0>>3 reaches the card register selected by address bits [2:0]. The select encoding is 0 data, 1 error, 2 sector count, 3 sector number, 4 cylinder low, 5 cylinder high, 6 drive/head, 7 status/command.
- R8: An I/O write to 0xB0 loads the remap bit from data bit 0. Writing 0 returns the window to memory, and writing 1 restores it.
- R9: A button press aborts any activity, re-asserts `cpu_rst_n` on the next clock, sets the remap bit, and repeats the whole sequence from R2.
- R10: Each card access drives chip select for one clock before the strobe, holds the strobe low for `STB_CLKS` clocks (default 4), and keeps chip select low for one clock after the strobe.
- R11: The read and write strobes are never low together, and neither is low unless chip select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| btn_press | input | 1 | Synchronous reset-button request, active high |
| cpu_rst_n | output | 1 | Reset to the processor, active low |
| cpu_addr | input | 16 | Processor address |
| cpu_mem | input | 1 | 1 = memory cycle, 0 = I/O cycle |
| cpu_rd | input | 1 | Processor read request, held until acknowledged |
| cpu_wr | input | 1 | Processor write request, held until acknowledged |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Data returned for a card access |
| cpu_ack | output | 1 | One-clock completion pulse for card or control accesses |
| mem_sel | output | 1 | Routes the current memory cycle to normal memory |
| cf_sel | output | 3 | Card register select |
| cf_cs_n | output | 1 | Card chip select, active low |
| cf_rd_n | output | 1 | Card read strobe, active low |
| cf_wr_n | output | 1 | Card write strobe, active low |
| cf_dout | output | 16 | Data driven to the card |
| cf_oe | output | 1 | Output enable for `cf_dout` |
| cf_din | input | 16 | Data from the card |

## Verification
The hardest case to reach is a button press after the processor is running and the window has already been switched back to memory. This is where stale remap or pointer state would show. The bench boots once and streams sector words through scattered window addresses. It then clears and restores the remap bit and presses the button. The card model reports busy for a while, so the ready and data-request polls each loop more than once. The bench expects the full write sequence again, and expects the first word after the second release to be word 0 of the sector.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

   typedef enum logic [2:0] {
      TF_DATA  = 3'd0,
      TF_ERR   = 3'd1,
      TF_SCNT  = 3'd2,
      TF_SNUM  = 3'd3,
      TF_CYLL  = 3'd4,
      TF_CYLH  = 3'd5,
      TF_DRVH  = 3'd6,
      TF_STCMD = 3'd7
   } tf_sel_e;

   localparam int unsigned ST_BUSY_BIT  = 7;
   localparam int unsigned ST_READY_BIT = 6;
   localparam int unsigned ST_DREQ_BIT  = 3;
   localparam int unsigned BUS_W        = 16;

   typedef struct packed {
      logic             wr;
      tf_sel_e          sel;
      logic [BUS_W-1:0] wdata;
   } card_req_t;

endpackage

// File: rtl/cfb_cycle.sv
module cfb_cycle
   import cfb_pkg::*;
#(
   parameter int unsigned STB_CLKS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             start,
   input  card_req_t        req,
   input  logic [BUS_W-1:0] cf_din,
   output logic             busy,
   output logic             done,
   output logic [BUS_W-1:0] rdata,
   output logic [2:0]       cf_sel,
   output logic             cf_cs_n,
   output logic             cf_rd_n,
   output logic             cf_wr_n,
   output logic [BUS_W-1:0] cf_dout,
   output logic             cf_oe
);

   localparam int unsigned CNT_W = (STB_CLKS > 1) ? $clog2(STB_CLKS) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STB_CLKS - 1);

   if (STB_CLKS < 1) begin : g_bad_stb
      $error("cfb_cycle: STB_CLKS must be at least 1");
   end

   typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STB, PH_HOLD} phase_e;

   phase_e     ph_q;
   logic [CNT_W-1:0] cnt_q;
   card_req_t  req_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
         req_q <= '0;
         rdata <= '0;
         done  <= 1'b0;
      end else if (clr) begin
         ph_q  <= PH_IDLE;
         cnt_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (ph_q)
            PH_IDLE: if (start) begin
               req_q <= req;
               ph_q  <= PH_SETUP;
            end
            PH_SETUP: begin
               cnt_q <= '0;
               ph_q  <= PH_STB;
            end
            PH_STB: begin
               if (cnt_q == CNT_LAST) begin
                  if (!req_q.wr) rdata <= cf_din;
                  ph_q <= PH_HOLD;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            PH_HOLD: begin
               done <= 1'b1;
               ph_q <= PH_IDLE;
            end
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign busy    = (ph_q != PH_IDLE);
   assign cf_sel  = req_q.sel;
   assign cf_cs_n = (ph_q == PH_IDLE);
   assign cf_rd_n = !((ph_q == PH_STB) && !req_q.wr);
   assign cf_wr_n = !((ph_q == PH_STB) &&  req_q.wr);
   assign cf_oe   = (ph_q != PH_IDLE) && req_q.wr;
   assign cf_dout = req_q.wdata;

endmodule

// File: rtl/cfb_boot_fsm.sv
module cfb_boot_fsm
   import cfb_pkg::*;
#(
   parameter logic [7:0] SECT_COUNT = 8'h01,
   parameter logic [7:0] SECT_FIRST = 8'h01,
   parameter logic [7:0] READ_CMD   = 8'h20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             cyc_done,
   input  logic [BUS_W-1:0] cyc_rdata,
   output logic             start,
   output card_req_t        req,
   output logic             run
);

   localparam int unsigned NUM_WR = 6;
   localparam int unsigned IDX_W  = $clog2(NUM_WR);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_WR - 1);

   typedef enum logic [2:0] {
      B_RDY_GO, B_RDY_WT, B_WR_GO, B_WR_WT, B_DRQ_GO, B_DRQ_WT, B_RUN
   } boot_e;

   boot_e st_q;
   logic [IDX_W-1:0] idx_q;

   function automatic card_req_t wr_step(input logic [IDX_W-1:0] i);
      card_req_t r;
      r.wr = 1'b1;
      unique case (i)
         IDX_W'(0): begin r.sel = TF_SCNT;  r.wdata = {8'h00, SECT_COUNT}; end
         IDX_W'(1): begin r.sel = TF_SNUM;  r.wdata = {8'h00, SECT_FIRST}; end
         IDX_W'(2): begin r.sel = TF_CYLL;  r.wdata = 16'h0000; end
         IDX_W'(3): begin r.sel = TF_CYLH;  r.wdata = 16'h0000; end
         IDX_W'(4): begin r.sel = TF_DRVH;  r.wdata = 16'h0000; end
         default:   begin r.sel = TF_STCMD; r.wdata = {8'h00, READ_CMD}; end
      endcase
      return r;
   endfunction

   logic card_ready, card_dreq;
   assign card_ready = !cyc_rdata[ST_BUSY_BIT] && cyc_rdata[ST_READY_BIT];
   assign card_dreq  = !cyc_rdata[ST_BUSY_BIT] && cyc_rdata[ST_DREQ_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= B_RDY_GO;
         idx_q <= '0;
      end else if (clr) begin
         st_q  <= B_RDY_GO;
         idx_q <= '0;
      end else begin
         unique case (st_q)
            B_RDY_GO: st_q <= B_RDY_WT;
            B_RDY_WT: if (cyc_done) begin
               idx_q <= '0;
               st_q  <= card_ready ? B_WR_GO : B_RDY_GO;
            end
            B_WR_GO:  st_q <= B_WR_WT;
            B_WR_WT:  if (cyc_done) begin
               if (idx_q == IDX_LAST) begin
                  st_q <= B_DRQ_GO;
               end else begin
                  idx_q <= idx_q + 1'b1;
                  st_q  <= B_WR_GO;
               end
            end
            B_DRQ_GO: st_q <= B_DRQ_WT;
            B_DRQ_WT: if (cyc_done) st_q <= card_dreq ? B_RUN : B_DRQ_GO;
            B_RUN:    st_q <= B_RUN;
            default:  st_q <= B_RDY_GO;
         endcase
      end
   end

   always_comb begin
      start = (st_q == B_RDY_GO) || (st_q == B_WR_GO) || (st_q == B_DRQ_GO);
      if ((st_q == B_WR_GO) || (st_q == B_WR_WT)) begin
         req = wr_step(idx_q);
      end else begin
         req.wr    = 1'b0;
         req.sel   = TF_STCMD;
         req.wdata = '0;
      end
   end

   assign run = (st_q == B_RUN);

endmodule

// File: rtl/cfb_cpu_port.sv
module cfb_cpu_port
   import cfb_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter int unsigned WIN_BYTES = 512,
   parameter logic [7:0]  IO_BASE   = 8'hC0,
   parameter logic [7:0]  CTRL_IO   = 8'hB0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              run,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_mem,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [BUS_W-1:0]  cpu_wdata,
   input  logic              cyc_busy,
   input  logic              cyc_done,
   input  logic [BUS_W-1:0]  cyc_rdata,
   output logic              start,
   output card_req_t         req,
   output logic [BUS_W-1:0]  cpu_rdata,
   output logic              cpu_ack,
   output logic              mem_sel,
   output logic              remap
);

   localparam int unsigned WIN_LG = $clog2(WIN_BYTES);

   if (ADDR_W < 8) begin : g_bad_aw
      $error("cfb_cpu_port: ADDR_W must be at least 8");
   end
   if ((1 << WIN_LG) != WIN_BYTES) begin : g_bad_win
      $error("cfb_cpu_port: WIN_BYTES must be a power of two");
   end

   logic in_win;
   if (WIN_LG >= ADDR_W) begin : g_win_all
      assign in_win = 1'b1;
   end else begin : g_win_cmp
      assign in_win = (cpu_addr[ADDR_W-1:WIN_LG] == '0);
   end

   logic io_hit, ctrl_hit, armed_q, inflight_q, hit_card, hit_ctrl, win_rd;

   assign io_hit   = !cpu_mem && (cpu_addr[7:3] == IO_BASE[7:3]);
   assign ctrl_hit = !cpu_mem && (cpu_addr[7:0] == CTRL_IO);
   assign win_rd   = cpu_mem && cpu_rd && in_win && remap;

   assign hit_card = run && armed_q && !inflight_q && !cyc_busy &&
                     (win_rd || (io_hit && (cpu_rd || cpu_wr)));
   assign hit_ctrl = run && armed_q && !inflight_q && ctrl_hit && cpu_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remap      <= 1'b1;
         armed_q    <= 1'b0;
         inflight_q <= 1'b0;
         cpu_ack    <= 1'b0;
         cpu_rdata  <= '0;
      end else if (clr) begin
         remap      <= 1'b1;
         armed_q    <= 1'b0;
         inflight_q <= 1'b0;
         cpu_ack    <= 1'b0;
      end else begin
         cpu_ack <= 1'b0;
         if (!(cpu_rd || cpu_wr)) armed_q <= 1'b1;
         if (hit_card) begin
            inflight_q <= 1'b1;
            armed_q    <= 1'b0;
         end
         if (inflight_q && cyc_done) begin
            inflight_q <= 1'b0;
            cpu_ack    <= 1'b1;
            cpu_rdata  <= cyc_rdata;
         end
         if (hit_ctrl) begin
            remap   <= cpu_wdata[0];
            armed_q <= 1'b0;
            cpu_ack <= 1'b1;
         end
      end
   end

   always_comb begin
      start     = hit_card;
      req.wr    = cpu_wr && !cpu_mem;
      req.sel   = cpu_mem ? TF_DATA : tf_sel_e'(cpu_addr[2:0]);
      req.wdata = cpu_wdata;
   end

   assign mem_sel = run && cpu_mem && (cpu_rd || cpu_wr) && !win_rd;

endmodule

// File: rtl/cf_boot_seq.sv
module cf_boot_seq
   import cfb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter int unsigned WIN_BYTES  = 512,
   parameter int unsigned STB_CLKS   = 4,
   parameter logic [7:0]  IO_BASE    = 8'hC0,
   parameter logic [7:0]  CTRL_IO    = 8'hB0,
   parameter logic [7:0]  SECT_COUNT = 8'h01,
   parameter logic [7:0]  SECT_FIRST = 8'h01,
   parameter logic [7:0]  READ_CMD   = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              btn_press,
   output logic              cpu_rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_mem,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [15:0]       cpu_wdata,
   output logic [15:0]       cpu_rdata,
   output logic              cpu_ack,
   output logic              mem_sel,
   output logic [2:0]        cf_sel,
   output logic              cf_cs_n,
   output logic              cf_rd_n,
   output logic              cf_wr_n,
   output logic [15:0]       cf_dout,
   output logic              cf_oe,
   input  logic [15:0]       cf_din
);

   logic      boot_run, boot_start, cpu_start, cyc_start, cyc_busy, cyc_done;
   logic      remap_en;
   card_req_t boot_req, cpu_req, cyc_req;
   logic [BUS_W-1:0] cyc_rdata;

   cfb_boot_fsm #(
      .SECT_COUNT(SECT_COUNT), .SECT_FIRST(SECT_FIRST), .READ_CMD(READ_CMD)
   ) u_boot (
      .clk(clk), .rst_n(rst_n), .clr(btn_press),
      .cyc_done(cyc_done), .cyc_rdata(cyc_rdata),
      .start(boot_start), .req(boot_req), .run(boot_run)
   );

   cfb_cpu_port #(
      .ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .IO_BASE(IO_BASE), .CTRL_IO(CTRL_IO)
   ) u_cpu (
      .clk(clk), .rst_n(rst_n), .clr(btn_press), .run(boot_run),
      .cpu_addr(cpu_addr), .cpu_mem(cpu_mem), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .cyc_busy(cyc_busy), .cyc_done(cyc_done),
      .cyc_rdata(cyc_rdata), .start(cpu_start), .req(cpu_req),
      .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack), .mem_sel(mem_sel), .remap(remap_en)
   );

   assign cyc_start = boot_run ? cpu_start : boot_start;
   assign cyc_req   = boot_run ? cpu_req   : boot_req;

   cfb_cycle #(.STB_CLKS(STB_CLKS)) u_cyc (
      .clk(clk), .rst_n(rst_n), .clr(btn_press),
      .start(cyc_start), .req(cyc_req), .cf_din(cf_din),
      .busy(cyc_busy), .done(cyc_done), .rdata(cyc_rdata),
      .cf_sel(cf_sel), .cf_cs_n(cf_cs_n), .cf_rd_n(cf_rd_n), .cf_wr_n(cf_wr_n),
      .cf_dout(cf_dout), .cf_oe(cf_oe)
   );

   assign cpu_rst_n = boot_run;

endmodule

// File: rtl/cfb_checker.sv
module cfb_checker #(
   parameter int unsigned STB_CLKS = 4
) (
   input logic clk,
   input logic rst_n,
   input logic btn_press,
   input logic cpu_rst_n,
   input logic mem_sel,
   input logic remap,
   input logic cf_cs_n,
   input logic cf_rd_n,
   input logic cf_wr_n
);

   logic        stb_low;
   logic [15:0] low_run;
   assign stb_low = !cf_rd_n || !cf_wr_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       low_run <= '0;
      else if (stb_low) low_run <= low_run + 1'b1;
      else              low_run <= '0;
   end

   p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(!cf_rd_n && !cf_wr_n));

   p_strobe_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
      stb_low |-> !cf_cs_n);

   p_setup_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cf_rd_n) || $fell(cf_wr_n)) |-> $past(!cf_cs_n));

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cf_rd_n) || $rose(cf_wr_n)) |-> !cf_cs_n);

   p_strobe_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stb_low |-> (low_run < 16'(STB_CLKS)));

   p_release_remap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_rst_n) |-> remap);

   p_button_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
      btn_press |=> (!cpu_rst_n && remap));

   p_mem_after_boot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_sel |-> cpu_rst_n);

endmodule

bind cf_boot_seq cfb_checker #(.STB_CLKS(STB_CLKS)) u_chk (
   .clk(clk), .rst_n(rst_n), .btn_press(btn_press), .cpu_rst_n(cpu_rst_n),
   .mem_sel(mem_sel), .remap(remap_en), .cf_cs_n(cf_cs_n),
   .cf_rd_n(cf_rd_n), .cf_wr_n(cf_wr_n)
);

// File: tb/sim_cf_boot_seq.sv
`timescale 1ns/1ps
module sim_cf_boot_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        btn_press = 1'b0;
   logic        cpu_rst_n;
   logic [15:0] cpu_addr = '0;
   logic        cpu_mem = 1'b0, cpu_rd = 1'b0, cpu_wr = 1'b0;
   logic [15:0] cpu_wdata = '0;
   logic [15:0] cpu_rdata;
   logic        cpu_ack, mem_sel;
   logic [2:0]  cf_sel;
   logic        cf_cs_n, cf_rd_n, cf_wr_n, cf_oe;
   logic [15:0] cf_dout, cf_din;

   always #2.5 clk = ~clk;

   cf_boot_seq u0 (
      .clk(clk), .rst_n(rst_n), .btn_press(btn_press), .cpu_rst_n(cpu_rst_n),
      .cpu_addr(cpu_addr), .cpu_mem(cpu_mem), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
      .mem_sel(mem_sel), .cf_sel(cf_sel), .cf_cs_n(cf_cs_n), .cf_rd_n(cf_rd_n),
      .cf_wr_n(cf_wr_n), .cf_dout(cf_dout), .cf_oe(cf_oe), .cf_din(cf_din)
   );

   int checks = 0;
   int errors = 0;

   task automatic chk(input bit ok, input string req, input logic [15:0] act,
                      input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // ---------------- card model ----------------
   logic [15:0] sector [256];
   logic [7:0]  tfreg  [8];
   logic [7:0]  stat = 8'h80;
   logic [7:0]  ptr = '0;
   int          busy_left = 0;
   bit          card_ready = 0;
   bit          drq_seen = 0;
   bit          prev_rd_n = 1, prev_wr_n = 1, prev_cs_n = 1;
   int          rd_low = 0, wr_low = 0;
   int          rdy_polls = 0;
   int          wr_count = 0;

   initial begin
      for (int i = 0; i < 256; i++) sector[i] = 16'(i * 263 + 16'h1234);
      for (int i = 0; i < 8; i++) tfreg[i] = 8'h00;
   end

   always_comb begin
      if (cf_sel == 3'd0)      cf_din = sector[ptr];
      else if (cf_sel == 3'd7) cf_din = {8'h00, stat};
      else                     cf_din = {8'h00, tfreg[cf_sel]};
   end

   typedef struct packed { logic [2:0] sel; logic [7:0] val; } wr_item_t;
   wr_item_t wr_exp[$];

   always @(negedge clk) begin
      if (busy_left > 0) begin
         busy_left <= busy_left - 1;
         if (busy_left == 1) stat <= 8'h48;
      end
      // strobe width and setup (R10)
      if (!cf_rd_n) begin
         if (prev_rd_n) chk(!prev_cs_n, "R10 setup", 16'(prev_cs_n), 16'h0);
         rd_low <= rd_low + 1;
      end
      if (!cf_wr_n) begin
         if (prev_wr_n) chk(!prev_cs_n, "R10 setup", 16'(prev_cs_n), 16'h0);
         wr_low <= wr_low + 1;
      end
      if (cf_rd_n && !prev_rd_n) begin
         chk(rd_low == 4, "R10 read strobe width", 16'(rd_low), 16'd4);
         chk(!cf_cs_n, "R10 hold", 16'(cf_cs_n), 16'h0);
         rd_low <= 0;
         if (cf_sel == 3'd0) ptr <= ptr + 1'b1;
         if (cf_sel == 3'd7) begin
            if (!card_ready) rdy_polls <= rdy_polls + 1;
            if (!stat[7] && stat[3]) drq_seen <= 1;
         end
      end
      if (cf_wr_n && !prev_wr_n) begin
         chk(wr_low == 4, "R10 write strobe width", 16'(wr_low), 16'd4);
         wr_low <= 0;
         wr_count <= wr_count + 1;
         chk(card_ready, "R2 write before ready", 16'(card_ready), 16'h1);
         if (wr_exp.size() == 0) begin
            chk(0, "R3 unexpected write", {5'd0, cf_sel, cf_dout[7:0]}, 16'h0);
         end else begin
            wr_item_t e;
            e = wr_exp.pop_front();
            chk(cf_sel == e.sel && cf_dout[7:0] == e.val, "R3 write order",
                {5'd0, cf_sel, cf_dout[7:0]}, {5'd0, e.sel, e.val});
         end
         tfreg[cf_sel] <= cf_dout[7:0];
         if (cf_sel == 3'd7 && cf_dout[7:0] == 8'h20) begin
            stat <= 8'h80; busy_left <= 30; ptr <= '0; drq_seen <= 0;
         end
      end
      prev_rd_n <= cf_rd_n; prev_wr_n <= cf_wr_n; prev_cs_n <= cf_cs_n;
   end

   // R4: release only after a data-request status read
   logic prev_cpu_rst_n = 0;
   always @(negedge clk) begin
      if (rst_n && cpu_rst_n && !prev_cpu_rst_n)
         chk(drq_seen, "R4 release before data request", 16'(drq_seen), 16'h1);
      if (rst_n && mem_sel)
         chk(cpu_rst_n, "R6 mem_sel in reset", 16'(cpu_rst_n), 16'h1);
      prev_cpu_rst_n <= cpu_rst_n;
   end

   // ---------------- read scoreboard ----------------
   logic [15:0] rd_exp[$];
   string       rd_tag[$];
   bit          rd_pending = 0;

   always @(negedge clk) begin
      if (cpu_ack && rd_pending) begin
         if (rd_exp.size() == 0) begin
            chk(0, "scoreboard empty", cpu_rdata, 16'h0);
         end else begin
            logic [15:0] e;
            string t;
            e = rd_exp.pop_front();
            t = rd_tag.pop_front();
            chk(cpu_rdata == e, t, cpu_rdata, e);
         end
      end
   end

   task automatic push_boot_writes();
      wr_exp.push_back({3'd2, 8'h01});
      wr_exp.push_back({3'd3, 8'h01});
      wr_exp.push_back({3'd4, 8'h00});
      wr_exp.push_back({3'd5, 8'h00});
      wr_exp.push_back({3'd6, 8'h00});
      wr_exp.push_back({3'd7, 8'h20});
   endtask

   task automatic card_access(input bit mem, input bit wr, input logic [15:0] addr,
                              input logic [15:0] wdata, input logic [15:0] exp,
                              input string tag);
      int n;
      @(negedge clk);
      if (!wr) begin
         rd_exp.push_back(exp);
         rd_tag.push_back(tag);
      end
      rd_pending = !wr;
      cpu_mem = mem; cpu_rd = !wr; cpu_wr = wr; cpu_addr = addr; cpu_wdata = wdata;
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!cpu_ack && n < 100);
      chk(cpu_ack, {tag, " no ack"}, 16'(cpu_ack), 16'h1);
      cpu_rd = 0; cpu_wr = 0; rd_pending = 0;
      @(negedge clk);
   endtask

   task automatic mem_access(input bit wr, input logic [15:0] addr, input string tag);
      bit card_touched;
      @(negedge clk);
      cpu_mem = 1; cpu_rd = !wr; cpu_wr = wr; cpu_addr = addr;
      card_touched = 0;
      @(negedge clk);
      chk(mem_sel, {tag, " mem_sel"}, 16'(mem_sel), 16'h1);
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (!cf_cs_n) card_touched = 1;
      end
      chk(!card_touched, {tag, " card strobed"}, 16'(card_touched), 16'h0);
      cpu_rd = 0; cpu_wr = 0;
      @(negedge clk);
   endtask

   task automatic wait_release(input string tag);
      int n = 0;
      while (!cpu_rst_n && n < 3000) begin
         @(negedge clk);
         n++;
      end
      chk(cpu_rst_n, tag, 16'(cpu_rst_n), 16'h1);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         chk(0, "watchdog", 16'h0, 16'h1);
         finish_run();
      end
   end

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!cpu_rst_n, "R1 reset holds cpu", 16'(cpu_rst_n), 16'h0);
      chk(!mem_sel, "R1 no mem_sel in reset", 16'(mem_sel), 16'h0);
      push_boot_writes();
      repeat (60) @(negedge clk);
      chk(wr_count == 0, "R2 no write while busy", 16'(wr_count), 16'h0);
      chk(!cpu_rst_n, "R1 still in reset while busy", 16'(cpu_rst_n), 16'h0);
      stat = 8'h50; card_ready = 1;
      wait_release("R4 release");
      chk(rdy_polls >= 2, "R2 status polled", 16'(rdy_polls), 16'd2);
      chk(wr_exp.size() == 0 && wr_count == 6, "R3 six writes",
          16'(wr_count), 16'd6);

      // R5: streaming, address ignored
      card_access(1, 0, 16'h0000, 0, sector[0], "R5 word0");
      card_access(1, 0, 16'h0002, 0, sector[1], "R5 word1");
      card_access(1, 0, 16'h01FE, 0, sector[2], "R5 word2");
      card_access(1, 0, 16'h00F0, 0, sector[3], "R5 word3");

      // R6: outside window and writes go to memory
      mem_access(0, 16'h0200, "R6 read above window");
      mem_access(1, 16'h0010, "R6 write in window");

      // R7: I/O path to card registers
      card_access(0, 0, 16'h00C2, 0, 16'h0001, "R7 sector count readback");
      card_access(0, 0, 16'h00C7, 0, 16'h0048, "R7 status read");
      wr_exp.push_back({3'd3, 8'h5A});
      card_access(0, 1, 16'h00C3, 16'h005A, 0, "R7 io write");
      card_access(0, 0, 16'h00C3, 0, 16'h005A, "R7 io readback");

      // R8: remap off then on
      card_access(0, 1, 16'h00B0, 16'h0000, 0, "R8 clear remap");
      mem_access(0, 16'h0000, "R8 window to memory");
      card_access(0, 1, 16'h00B0, 16'h0001, 0, "R8 set remap");
      card_access(1, 0, 16'h0004, 0, sector[4], "R8 window restored");

      // R9: button repeats the sequence
      card_access(0, 1, 16'h00B0, 16'h0000, 0, "R9 clear remap before button");
      @(negedge clk);
      stat = 8'h80; card_ready = 0; wr_count = 0;
      btn_press = 1;
      @(negedge clk);
      btn_press = 0;
      chk(!cpu_rst_n, "R9 reset reasserted", 16'(cpu_rst_n), 16'h0);
      push_boot_writes();
      repeat (40) @(negedge clk);
      chk(wr_count == 0, "R9 waits for ready", 16'(wr_count), 16'h0);
      stat = 8'h50; card_ready = 1;
      wait_release("R9 second release");
      chk(wr_exp.size() == 0 && wr_count == 6, "R9 writes repeated",
          16'(wr_count), 16'd6);
      card_access(1, 0, 16'h0100, 0, sector[0], "R9 remap restored word0");
      card_access(1, 0, 16'h0000, 0, sector[1], "R9 word1");

      repeat (5) @(negedge clk);
      finish_run();
   end

endmodule